// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It runs on a fast prescaler clock and sees two one-cycle pulses: `ref_pulse` marks an edge of the reference clock and `fb_pulse` marks an edge of the divided feedback clock. Each reference edge opens a sync window. The window is placed around the reference edge by delaying the feedback pulse through a short delay line. The window is two or four prescaler cycles wide, as `win_sel` selects.

A reference period passes when exactly one feedback edge lands inside its window. The block counts passing periods in a row. It raises `locked` once the count reaches the threshold that `thr_sel` selects, and the count then holds at that value. A period that fails clears the count and drops `locked`. Pulling `en` low, which models the synthesizer being powered down, clears everything.

The threshold and window settings are taken at each reference edge. A new value restarts the count, and that period is the first one counted under the new settings. Reference pulses are assumed to be one cycle wide and at least six prescaler cycles apart. Feedback pulses are one cycle wide. No pin carries streamed data, so the block has no valid/ready handshake and all pins are plain level or pulse signals.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `locked` and `win_dbg` are 0. The active settings are threshold code 01 (128 periods) and the short window.
- R2: The threshold code picks how many passing periods in a row are needed for `locked`: 00 means 64, 01 means 128, 10 means 256 and 11 means 512. `locked` stays 0 after one period fewer than the threshold and is 1 after exactly the threshold.
- R3: With `win_sel`=0 the window lasts 2 prescaler cycles, and with `win_sel`=1 it lasts 4. `win_dbg` is high for exactly that many cycles, starting in the cycle after the `ref_pulse` cycle.
- R4: Let d be the cycle of a feedback pulse minus the cycle of the reference pulse. The pulse is inside the window for the short setting when d is 0 or 1, and for the long setting when d is -1, 0, 1 or 2. Any other d is outside.
- R5: A period passes only when exactly one feedback pulse is inside its window. No pulse inside, or two pulses inside, is a failure.
- R6: A failed period clears the count and drops `locked` at the window close. Reaching lock again then takes the full threshold.
- R7: Once locked, the count holds at the threshold. Further passing periods keep `locked` high and do not wrap the count.
- R8: While `en` is 0 the count, `locked` and the window are all cleared, and reference pulses open no window. After `en` returns to 1, the full threshold is needed again.
- R9: `thr_sel` and `win_sel` are sampled on the `ref_pulse` cycle. A value that differs from the active one restarts the count at 0 and drops `locked`, and that period counts as the first under the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Synthesizer enabled; 0 clears the detector |
| ref_pulse | input | 1 | One-cycle pulse per reference edge |
| fb_pulse | input | 1 | One-cycle pulse per feedback edge |
| thr_sel | input | 2 | Lock threshold code |
| win_sel | input | 1 | Window width select: 0 short, 1 long |
| locked | output | 1 | 1 while the loop is judged in lock |
| win_dbg | output | 1 | Sync window, for debug |

## Verification
The bench drives feedback edges at both ends of each window setting and one cycle past each end. A window that is misplaced or one cycle too short or too long would then accept an edge it should reject, or reject one it should accept. Each threshold code is run to one period short of its count and then to the count itself, so an off-by-one or a swapped encoding shows as a wrong `locked` value. A double edge inside one window checks that the block does not count mere presence of an edge. Changing a setting while locked, dropping `en` while locked, and a failed period after saturation check that the count really restarts; a counter that kept its old value would re-lock too early.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;

  // Settings captured at each reference edge
  typedef struct packed {
    logic [1:0] thr;
    logic       wide;
  } lockdet_cfg_t;

  localparam logic [1:0] THR_RESET = 2'b01;

  // Passing periods needed for a given threshold code
  function automatic int unsigned lock_need(input logic [1:0] code,
                                            input int unsigned base);
    return base << code;
  endfunction

endpackage

// File: rtl/lockdet_cfg.sv
`timescale 1ns/1ps
module lockdet_cfg
  import lockdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ref_pulse,
  input  logic [1:0] thr_sel,
  input  logic       win_sel,
  output logic [1:0] thr_act,
  output logic       restart
);

  lockdet_cfg_t act_q;
  lockdet_cfg_t req;

  assign req     = '{thr: thr_sel, wide: win_sel};
  assign restart = en && ref_pulse && (req != act_q);
  assign thr_act = act_q.thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '{thr: THR_RESET, wide: 1'b0};
    end else if (ref_pulse) begin
      act_q <= req;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_pulse |=> $stable(act_q));

endmodule

// File: rtl/lockdet_window.sv
`timescale 1ns/1ps
module lockdet_window #(
  parameter int unsigned WIN_SHORT = 2,
  parameter int unsigned WIN_LONG  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic win_sel,
  output logic win_on,
  output logic period_done,
  output logic period_ok
);

  localparam int unsigned DLY     = WIN_LONG / 2;
  localparam int unsigned TAP_S   = WIN_SHORT / 2 - 1;
  localparam int unsigned TAP_L   = WIN_LONG / 2 - 1;
  localparam int unsigned CW      = (WIN_LONG > 2) ? $clog2(WIN_LONG) : 1;
  localparam int unsigned RW      = $clog2(WIN_LONG + 2);

  logic [DLY-1:0] fb_sh;
  logic [CW-1:0]  win_cnt;
  logic [1:0]     hits;
  logic [1:0]     hits_nx;
  logic           wide_q;
  logic           tap;

  // Feedback delay line: centres the window on the reference edge
  generate
    if (DLY == 1) begin : g_dly1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fb_sh <= '0;
        else if (!en) fb_sh <= '0;
        else          fb_sh <= fb_pulse;
      end
    end else begin : g_dlyn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fb_sh <= '0;
        else if (!en) fb_sh <= '0;
        else          fb_sh <= {fb_sh[DLY-2:0], fb_pulse};
      end
    end
  endgenerate

  assign tap         = wide_q ? fb_sh[TAP_L] : fb_sh[TAP_S];
  assign hits_nx     = (hits == 2'd2) ? 2'd2 : hits + {1'b0, tap};
  assign period_done = en && win_on && (win_cnt == '0) && !ref_pulse;
  assign period_ok   = (hits_nx == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_on  <= 1'b0;
      win_cnt <= '0;
      hits    <= '0;
      wide_q  <= 1'b0;
    end else if (!en) begin
      win_on  <= 1'b0;
      win_cnt <= '0;
      hits    <= '0;
    end else if (ref_pulse) begin
      win_on  <= 1'b1;
      win_cnt <= win_sel ? CW'(WIN_LONG - 1) : CW'(WIN_SHORT - 1);
      hits    <= '0;
      wide_q  <= win_sel;
    end else if (win_on) begin
      hits <= hits_nx;
      if (win_cnt == '0) win_on <= 1'b0;
      else               win_cnt <= win_cnt - 1'b1;
    end
  end

  // Checker-side run length of the window
  logic [RW-1:0] on_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          on_run <= '0;
    else if (ref_pulse)  on_run <= '0;
    else if (win_on)     on_run <= on_run + 1'b1;
    else                 on_run <= '0;
  end

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_on |-> on_run < RW'(wide_q ? WIN_LONG : WIN_SHORT));

  // R3
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_on) |-> $past(ref_pulse));

  // R8
  win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !win_on);

endmodule

// File: rtl/lockdet_counter.sv
`timescale 1ns/1ps
module lockdet_counter
  import lockdet_pkg::*;
#(
  parameter int unsigned THR_BASE = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic       period_done,
  input  logic       period_ok,
  input  logic [1:0] thr_code,
  output logic       locked
);

  localparam int unsigned CW = $clog2(THR_BASE * 8 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr_val;

  assign thr_val = CW'(lock_need(thr_code, THR_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!en || restart) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (period_done) begin
      if (period_ok) begin
        if (cnt < thr_val) cnt <= cnt + 1'b1;
        locked <= (cnt + 1'b1 >= thr_val);
      end else begin
        cnt    <= '0;
        locked <= 1'b0;
      end
    end
  end

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= thr_val);

  // R2
  lock_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> cnt == thr_val);

  // R6
  fail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && period_done && !period_ok) |=> (!locked && cnt == '0));

  // R8
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!locked && cnt == '0));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!locked && cnt == '0));

  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(period_done && period_ok));

endmodule

// File: rtl/pll_lock_detect.sv
`timescale 1ns/1ps
module pll_lock_detect #(
  parameter int unsigned THR_BASE  = 64,
  parameter int unsigned WIN_SHORT = 2,
  parameter int unsigned WIN_LONG  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ref_pulse,
  input  logic       fb_pulse,
  input  logic [1:0] thr_sel,
  input  logic       win_sel,
  output logic       locked,
  output logic       win_dbg
);

  logic [1:0] thr_act;
  logic       restart;
  logic       period_done;
  logic       period_ok;

  lockdet_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ref_pulse (ref_pulse),
    .thr_sel   (thr_sel),
    .win_sel   (win_sel),
    .thr_act   (thr_act),
    .restart   (restart)
  );

  lockdet_window #(
    .WIN_SHORT (WIN_SHORT),
    .WIN_LONG  (WIN_LONG)
  ) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .ref_pulse   (ref_pulse),
    .fb_pulse    (fb_pulse),
    .win_sel     (win_sel),
    .win_on      (win_dbg),
    .period_done (period_done),
    .period_ok   (period_ok)
  );

  lockdet_counter #(
    .THR_BASE (THR_BASE)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .restart     (restart),
    .period_done (period_done),
    .period_ok   (period_ok),
    .thr_code    (thr_act),
    .locked      (locked)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!locked && !win_dbg));

endmodule

// File: tb/sim_pll_lock_detect.sv
`timescale 1ns/1ps
module sim_pll_lock_detect;

  localparam int CLK_NS = 8;
  localparam int PER    = 16;
  localparam int REF_AT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       ref_pulse = 1'b0;
  logic       fb_pulse = 1'b0;
  logic [1:0] thr_sel = 2'b01;
  logic       win_sel = 1'b0;
  logic       locked;
  logic       win_dbg;

  int checks = 0;
  int failures = 0;
  int last_win_len = 0;

  always #(CLK_NS/2) clk = ~clk;

  pll_lock_detect u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse),
    .thr_sel   (thr_sel),
    .win_sel   (win_sel),
    .locked    (locked),
    .win_dbg   (win_dbg)
  );

  // Columns: thr, win, fb offset, double edge, repeats, expected lock, req tag
  localparam int NV = 17;
  localparam int VEC [NV][7] = '{
    '{1, 0,  0, 0, 127, 0, 2},  // R2: one short of 128
    '{1, 0,  0, 0,   1, 1, 2},  // R2: 128th
    '{1, 0,  0, 0,   5, 1, 7},  // R7: holds
    '{1, 0,  2, 0,   1, 0, 4},  // R4: d=2 outside short
    '{1, 0,  1, 0, 128, 1, 4},  // R4: d=1 inside short, R6 full relock
    '{1, 0, -1, 0,   1, 0, 4},  // R4: d=-1 outside short
    '{1, 1, -1, 0, 127, 0, 9},  // R9: window change restarts, d=-1 inside long
    '{1, 1,  2, 0,   1, 1, 4},  // R4: d=2 inside long
    '{1, 1,  3, 0,   1, 0, 4},  // R4: d=3 outside long
    '{0, 1,  0, 0,  63, 0, 2},  // R2: 64 less one
    '{0, 1,  0, 0,   1, 1, 2},  // R2: 64
    '{0, 1,  0, 1,   1, 0, 5},  // R5: two edges inside
    '{3, 0,  0, 0, 511, 0, 2},  // R2: 512 less one
    '{3, 0,  0, 0,   1, 1, 2},  // R2: 512
    '{2, 0,  0, 0, 255, 0, 9},  // R9: thr change drops lock
    '{2, 0,  0, 0,   1, 1, 2},  // R2: 256
    '{2, 0,  9, 0,   1, 0, 5}   // R5: no edge in window
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One reference period; outputs sampled at the negedge before driving
  task automatic run_period(input int off, input bit dbl);
    last_win_len = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (win_dbg) last_win_len++;
      ref_pulse = (i == REF_AT);
      fb_pulse  = (i == REF_AT + off) || (dbl && i == REF_AT + off + 1);
    end
    @(negedge clk);
    if (win_dbg) last_win_len++;
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 locked", int'(locked), 0);
    check("R1 win_dbg", int'(win_dbg), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      thr_sel = VEC[v][0][1:0];
      win_sel = VEC[v][1][0];
      for (int r = 0; r < VEC[v][4]; r++) run_period(VEC[v][2], VEC[v][3][0]);
      check($sformatf("R%0d vec%0d", VEC[v][6], v), int'(locked), VEC[v][5]);
    end

    // R3: window widths seen on win_dbg
    thr_sel = 2'b00;
    win_sel = 1'b0;
    run_period(0, 1'b0);
    check("R3 short width", last_win_len, 2);
    win_sel = 1'b1;
    run_period(0, 1'b0);
    check("R3 long width", last_win_len, 4);
    // R1: out-of-reset threshold is 128 (reset again, drive code 01)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    thr_sel = 2'b01;
    win_sel = 1'b0;
    for (int r = 0; r < 127; r++) run_period(0, 1'b0);
    check("R1 default thr not yet", int'(locked), 0);
    run_period(0, 1'b0);
    check("R1 default thr 128", int'(locked), 1);

    // R8: enable low clears and suppresses window
    en = 1'b0;
    run_period(0, 1'b0);
    check("R8 locked cleared", int'(locked), 0);
    check("R8 no window", last_win_len, 0);
    en = 1'b1;
    for (int r = 0; r < 127; r++) run_period(0, 1'b0);
    check("R8 full count needed", int'(locked), 0);
    run_period(0, 1'b0);
    check("R8 relock", int'(locked), 1);
    // R6: failure after saturation drops lock and a full count is needed
    run_period(9, 1'b0);
    check("R6 drop", int'(locked), 0);
    for (int r = 0; r < 127; r++) run_period(0, 1'b0);
    check("R6 no early relock", int'(locked), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule